// File: doc/BRIEF.md
# Transmit Frame CRC Inserter

This block sits in the transmit path ahead of the line encoder. It takes a stream of 32-bit words, each tagged with a flag saying whether its top byte is a control character, and recognises ordered sets by their leading comma byte. A start-of-frame ordered set opens a frame. Every plain data word that follows is folded into a CRC-32. When the frame is closed by an end-of-frame word, or by any other ordered set, the block stalls its source for one cycle, emits the inverted CRC as a data word, and then forwards the closing ordered set.

Two test and link features sit beside the main path. With idle skipping enabled, an idle ordered set found inside a frame is forwarded without ending the frame and without changing the CRC. This lets a sender pause a frame and resume it later. With the raw enable set, the CRC machinery is bypassed entirely. An extra byte is placed above the 32 data bits, and the 40-bit word goes straight to the output register, so that deliberately corrupted patterns can be sent.

Top module: `ftx_crc_inserter`

## Requirements
- R1: After a synchronous active-high reset, out_valid is 0, in_ready is 1 while no word is offered, no frame is open, and the CRC register holds all ones.
- R2: A word is an ordered set when in_ctrl is 1 and bits [31:24] equal 0xBC. It is an idle when bits [23:16] are 0x95 or 0xB5 and bits [15:0] are 0xB5B5. It is an end-of-frame when bits [23:16] are one of 0x95, 0xB5, 0x8A or 0xAA and bits [15:8] are one of 0x75, 0x95, 0xF5 or 0xD5. It is a start-of-frame when bits [23:16] are 0xB5 and it is neither of the above. Accepting a start-of-frame with crc_en high opens a frame. Any other ordered set accepted outside a skipped idle leaves the frame closed.
- R3: The CRC register is preset to all ones. For each data word accepted inside a frame it is updated with polynomial 0x04C11DB7, shifting MSB first, with bit 31 of the word entering first. The start-of-frame word is not included. The inserted word carries the bitwise inverse of the register.
- R4: When an ordered set that closes the frame is offered, in_ready is 0 for exactly that one cycle. On the next cycle the CRC word appears with out_ctrl 0. The ordered set is then accepted and appears one cycle after that.
- R5: With idle_skip_en high, an idle inside a frame is forwarded with no stall, the frame stays open, and the CRC is unchanged.
- R6: With idle_skip_en low, an idle inside a frame closes it, and a CRC word is inserted before the idle.
- R7: With raw_en high, a word is never stalled. It appears as {in_raw_hi, in_data} on {out_raw_hi, out_word} with in_ctrl on out_ctrl, and the frame and CRC state are left as they were.
- R8: With crc_en low, no CRC word is inserted, no stall occurs, and any accepted cooked word closes an open frame and presets the CRC register.
- R9: Each word accepted while raw_en is low appears one cycle later unchanged, with out_raw_hi equal to 0.
- R10: out_valid is 0 in any cycle that follows a cycle in which nothing was accepted and no CRC word was inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| crc_en | input | 1 | Enables frame tracking and CRC insertion |
| idle_skip_en | input | 1 | Keeps idles inside a frame out of the CRC |
| raw_en | input | 1 | Selects the 40-bit bypass path |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word taken when high together with in_valid |
| in_ctrl | input | 1 | Top byte of in_data is a control character |
| in_data | input | 32 | Input word |
| in_raw_hi | input | 8 | Upper byte used in raw mode |
| out_valid | output | 1 | Output word present |
| out_ctrl | output | 1 | Top byte of out_word is a control character |
| out_word | output | 32 | Output word |
| out_raw_hi | output | 8 | Upper byte, nonzero only in raw mode |

## Verification
The bench uses the default polynomial 0x04C11DB7 and an all-ones preset, so every inserted word can be compared with an MSB-first CRC computed independently in the bench. Random streams mix data words, data words that begin with 0xBC but have the control flag clear, and every ordered-set class. They also toggle the three mode inputs between frames. Together these reach back-to-back frames, a frame closed by a non-end-of-frame ordered set, a frame dropped by clearing crc_en, and raw words interleaved inside an open frame.

// File: rtl/ftx_pkg.sv
package ftx_pkg;

  typedef enum logic [2:0] {
    K_DATA  = 3'd0,
    K_SOF   = 3'd1,
    K_IDLE  = 3'd2,
    K_EOF   = 3'd3,
    K_OTHER = 3'd4
  } word_kind_t;

  localparam logic [7:0] COMMA = 8'hBC;

  // One 32-bit CRC step, MSB first, word bit 31 enters first.
  function automatic logic [31:0] crc_word_step(input logic [31:0] crc,
                                                input logic [31:0] din,
                                                input logic [31:0] poly);
    logic [31:0] c;
    logic        fb;
    c = crc;
    for (int i = 31; i >= 0; i--) begin
      fb = c[31] ^ din[i];
      c  = {c[30:0], 1'b0} ^ (fb ? poly : 32'h0);
    end
    return c;
  endfunction

  function automatic word_kind_t classify(input logic ctrl, input logic [31:0] d);
    logic b2_idle, b2_eof, b1_eof, lo_idle;
    if (!(ctrl && d[31:24] == COMMA)) return K_DATA;
    b2_idle = (d[23:16] == 8'h95) || (d[23:16] == 8'hB5);
    lo_idle = (d[15:0] == 16'hB5B5);
    b2_eof  = (d[23:16] == 8'h95) || (d[23:16] == 8'hB5) ||
              (d[23:16] == 8'h8A) || (d[23:16] == 8'hAA);
    b1_eof  = (d[15:8] == 8'h75) || (d[15:8] == 8'h95) ||
              (d[15:8] == 8'hF5) || (d[15:8] == 8'hD5);
    if (b2_idle && lo_idle) return K_IDLE;
    if (b2_eof && b1_eof)   return K_EOF;
    if (d[23:16] == 8'hB5)  return K_SOF;
    return K_OTHER;
  endfunction

endpackage

// File: rtl/ftx_classify.sv
module ftx_classify
  import ftx_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              ctrl,
  input  logic [WORD_W-1:0] data,
  output word_kind_t        kind,
  output logic              is_os
);
  always_comb begin
    kind  = classify(ctrl, data[31:0]);
    is_os = (kind != K_DATA);
  end
endmodule

// File: rtl/ftx_crc_reg.sv
module ftx_crc_reg
  import ftx_pkg::*;
#(
  parameter logic [31:0] POLY   = 32'h04C11DB7,
  parameter logic [31:0] PRESET = 32'hFFFFFFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        update,
  input  logic [31:0] din,
  output logic [31:0] crc_q
);
  always_ff @(posedge clk) begin
    if (rst || clear) crc_q <= PRESET;
    else if (update)  crc_q <= crc_word_step(crc_q, din, POLY);
  end
endmodule

// File: rtl/ftx_crc_inserter.sv
module ftx_crc_inserter
  import ftx_pkg::*;
#(
  parameter int          WORD_W = 32,
  parameter int          HI_W   = 8,
  parameter logic [31:0] POLY   = 32'h04C11DB7,
  parameter logic [31:0] PRESET = 32'hFFFFFFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              crc_en,
  input  logic              idle_skip_en,
  input  logic              raw_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_ctrl,
  input  logic [WORD_W-1:0] in_data,
  input  logic [HI_W-1:0]   in_raw_hi,
  output logic              out_valid,
  output logic              out_ctrl,
  output logic [WORD_W-1:0] out_word,
  output logic [HI_W-1:0]   out_raw_hi
);
  localparam int RAW_W = WORD_W + HI_W;

  word_kind_t  kind;
  logic        is_os;
  logic        frame_open, crc_sent;
  logic [31:0] crc_q;

  // named internal events, observed by the checker
  logic skip_idle, term_hit, ins_fire, acc_fire, cooked_acc;
  logic crc_clear, crc_update;

  ftx_classify #(.WORD_W(WORD_W)) u_cls (
    .ctrl (in_ctrl),
    .data (in_data),
    .kind (kind),
    .is_os(is_os)
  );

  always_comb begin
    skip_idle  = frame_open && idle_skip_en && (kind == K_IDLE);
    term_hit   = !raw_en && crc_en && frame_open && is_os && !skip_idle;
    ins_fire   = in_valid && term_hit && !crc_sent;
    in_ready   = !ins_fire;
    acc_fire   = in_valid && in_ready;
    cooked_acc = acc_fire && !raw_en;
    crc_clear  = cooked_acc && (!crc_en || (is_os && !skip_idle));
    crc_update = cooked_acc && crc_en && frame_open && !is_os;
  end

  ftx_crc_reg #(.POLY(POLY), .PRESET(PRESET)) u_crc (
    .clk   (clk),
    .rst   (rst),
    .clear (crc_clear),
    .update(crc_update),
    .din   (in_data[31:0]),
    .crc_q (crc_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_open <= 1'b0;
      crc_sent   <= 1'b0;
    end else begin
      if (crc_clear)       frame_open <= crc_en && (kind == K_SOF);
      if (ins_fire)        crc_sent   <= 1'b1;
      else if (cooked_acc) crc_sent   <= 1'b0;
    end
  end

  logic [RAW_W-1:0] raw_word;
  assign raw_word = {in_raw_hi, in_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_ctrl   <= 1'b0;
      out_word   <= '0;
      out_raw_hi <= '0;
    end else begin
      out_valid <= ins_fire || acc_fire;
      if (ins_fire) begin
        out_ctrl   <= 1'b0;
        out_word   <= WORD_W'(~crc_q);
        out_raw_hi <= '0;
      end else if (acc_fire) begin
        out_ctrl   <= in_ctrl;
        out_word   <= raw_word[WORD_W-1:0];
        out_raw_hi <= raw_en ? raw_word[RAW_W-1:WORD_W] : '0;
      end
    end
  end

endmodule

// File: rtl/ftx_crc_inserter_chk.sv
module ftx_crc_inserter_chk (
  input logic clk,
  input logic rst,
  input logic crc_en,
  input logic raw_en,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_ctrl,
  input logic acc_fire,
  input logic frame_open
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && !frame_open));
  // R4
  stall_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> in_ready);
  // R4
  stall_emits_crc_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> (out_valid && !out_ctrl));
  // R7
  raw_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && raw_en) |-> in_ready);
  // R8
  off_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !crc_en) |-> in_ready);
  // R10
  out_needs_input_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));
  // R2
  open_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_open) |-> $past(acc_fire && crc_en && !raw_en));
endmodule

bind ftx_crc_inserter ftx_crc_inserter_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .crc_en    (crc_en),
  .raw_en    (raw_en),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ctrl  (out_ctrl),
  .acc_fire  (acc_fire),
  .frame_open(frame_open)
);

// File: tb/tb_ftx_crc_inserter.sv
module tb_ftx_crc_inserter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic crc_en = 1'b0, idle_skip_en = 1'b0, raw_en = 1'b0;
  logic in_valid = 1'b0, in_ready, in_ctrl = 1'b0;
  logic [31:0] in_data = '0;
  logic [7:0]  in_raw_hi = '0;
  logic out_valid, out_ctrl;
  logic [31:0] out_word;
  logic [7:0]  out_raw_hi;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ftx_crc_inserter dut (
    .clk(clk), .rst(rst), .crc_en(crc_en), .idle_skip_en(idle_skip_en),
    .raw_en(raw_en), .in_valid(in_valid), .in_ready(in_ready),
    .in_ctrl(in_ctrl), .in_data(in_data), .in_raw_hi(in_raw_hi),
    .out_valid(out_valid), .out_ctrl(out_ctrl), .out_word(out_word),
    .out_raw_hi(out_raw_hi)
  );

  // bench model state
  bit          m_open, m_sent;
  logic [31:0] m_crc;
  logic [63:0] exp_pack;
  string       exp_tag = "R1";
  string       cur_tag = "";

  function automatic logic [31:0] ref_crc(input logic [31:0] c0, input logic [31:0] w);
    logic [31:0] c = c0;
    for (int j = 31; j >= 0; j--) begin
      logic top = c[31];
      c = c << 1;
      if (top != w[j]) c = c ^ 32'h04C11DB7;
    end
    return c;
  endfunction

  // 0 data, 1 sof, 2 idle, 3 eof, 4 other ordered set
  function automatic int ref_kind(input logic k, input logic [31:0] w);
    if (!k || w[31:24] != 8'hBC) return 0;
    if ((w[23:16] inside {8'h95, 8'hB5}) && w[15:0] == 16'hB5B5) return 2;
    if ((w[23:16] inside {8'h95, 8'hB5, 8'h8A, 8'hAA}) &&
        (w[15:8] inside {8'h75, 8'h95, 8'hF5, 8'hD5})) return 3;
    if (w[23:16] == 8'hB5) return 1;
    return 4;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pack_out(input logic v, input logic c, input logic [7:0] h, input logic [31:0] w);
    return v ? {22'd0, 1'b1, c, h, w} : 64'd0;
  endfunction

  task automatic model_reset();
    m_open = 0; m_sent = 0; m_crc = 32'hFFFFFFFF;
    exp_pack = 64'd0; exp_tag = "R1";
  endtask

  task automatic step(input logic v, input logic c, input logic [31:0] d, input logic [7:0] h,
                      input logic ce, input logic sk, input logic rw, output bit acc);
    logic [63:0] act;
    int  kd;
    bit  os, skip, term, ins, rdy;
    @(negedge clk);
    act = pack_out(out_valid, out_ctrl, out_raw_hi, out_word);
    chk(act == exp_pack, exp_tag, act, exp_pack);
    in_valid = v; in_ctrl = c; in_data = d; in_raw_hi = h;
    crc_en = ce; idle_skip_en = sk; raw_en = rw;
    #1;
    kd   = ref_kind(c, d);
    os   = (kd != 0);
    skip = m_open && sk && (kd == 2);
    term = !rw && ce && m_open && os && !skip;
    ins  = v && term && !m_sent;
    rdy  = !ins;
    chk(in_ready == rdy, "R4 ready", {63'd0, in_ready}, {63'd0, rdy});
    acc = v && rdy;
    if (ins) begin
      exp_pack = pack_out(1, 0, 8'h00, ~m_crc);
      exp_tag  = (cur_tag != "") ? cur_tag : "R3";
      m_sent   = 1;
    end else if (acc) begin
      exp_pack = pack_out(1, c, rw ? h : 8'h00, d);
      exp_tag  = rw ? "R7" : "R9";
      if (!rw) begin
        m_sent = 0;
        if (!ce) begin m_open = 0; m_crc = 32'hFFFFFFFF; end
        else if (os && !skip) begin m_open = (kd == 1); m_crc = 32'hFFFFFFFF; end
        else if (!os && m_open) m_crc = ref_crc(m_crc, d);
      end
    end else begin
      exp_pack = 64'd0;
      exp_tag  = "R10";
    end
  endtask

  task automatic send(input logic c, input logic [31:0] d, input logic [7:0] h,
                      input logic ce, input logic sk, input logic rw);
    bit acc = 0;
    while (!acc) step(1, c, d, h, ce, sk, rw, acc);
  endtask

  task automatic gap(input logic ce, input logic sk, input logic rw);
    bit acc;
    step(0, 0, 32'h0, 8'h0, ce, sk, rw, acc);
  endtask

  function automatic logic [31:0] pick_word(input int cls, output logic k);
    k = 1;
    case (cls)
      0: begin k = 0; return $urandom; end
      1: begin k = 0; return {8'hBC, 24'($urandom)}; end
      2: return 32'hBCB51717;
      3: return ($urandom % 2) ? 32'hBC95B5B5 : 32'hBCB5B5B5;
      4: return ($urandom % 2) ? 32'hBC957575 : 32'hBCAAD5D5;
      default: return ($urandom % 2) ? 32'hBC954A4A : 32'hBC55BF45;
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic k;
    logic [31:0] w;
    void'($urandom(32'd12345));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state, no word offered
    @(negedge clk);
    chk(out_valid == 0, "R1 out_valid", {63'd0, out_valid}, 64'd0);
    chk(in_ready == 1, "R1 in_ready", {63'd0, in_ready}, 64'd1);

    // R2 R3 R4 R9: basic frame closed by end-of-frame
    cur_tag = "R3";
    send(1, 32'hBCB51717, 0, 1, 0, 0);
    send(0, 32'h12345678, 0, 1, 0, 0);
    send(0, 32'hDEADBEEF, 0, 1, 0, 0);
    send(0, 32'hBC000000, 0, 1, 0, 0);
    send(1, 32'hBC957575, 0, 1, 0, 0);
    gap(1, 0, 0); gap(1, 0, 0);

    // R5: idle inside frame skipped
    cur_tag = "R5";
    send(1, 32'hBCB55757, 0, 1, 1, 0);
    send(0, 32'hA5A5A5A5, 0, 1, 1, 0);
    send(1, 32'hBC95B5B5, 0, 1, 1, 0);
    send(1, 32'hBCB5B5B5, 0, 1, 1, 0);
    send(0, 32'h00000001, 0, 1, 1, 0);
    send(1, 32'hBCAAD5D5, 0, 1, 1, 0);
    gap(1, 1, 0);

    // R6: idle closes the frame without skipping
    cur_tag = "R6";
    send(1, 32'hBCB53535, 0, 1, 0, 0);
    send(0, 32'hCAFEF00D, 0, 1, 0, 0);
    send(1, 32'hBC95B5B5, 0, 1, 0, 0);
    gap(1, 0, 0);

    // R7: raw words inside an open frame
    cur_tag = "R7";
    send(1, 32'hBCB51717, 0, 1, 0, 0);
    send(0, 32'h11112222, 0, 1, 0, 0);
    send(1, 32'hBC957575, 8'h5A, 1, 0, 1);
    send(0, 32'h33334444, 8'hC3, 1, 0, 1);
    send(0, 32'h55556666, 0, 1, 0, 0);
    send(1, 32'hBC957575, 0, 1, 0, 0);
    gap(1, 0, 0);

    // R8: crc disabled mid-frame and for a whole frame
    cur_tag = "R8";
    send(1, 32'hBCB51717, 0, 1, 0, 0);
    send(0, 32'h77778888, 0, 1, 0, 0);
    send(0, 32'h9999AAAA, 0, 0, 0, 0);
    send(1, 32'hBC957575, 0, 1, 0, 0);
    send(1, 32'hBCB51717, 0, 0, 0, 0);
    send(0, 32'h01020304, 0, 0, 0, 0);
    send(1, 32'hBC957575, 0, 0, 0, 0);
    gap(0, 0, 0);

    // R2: frame closed by another ordered set, then back-to-back start
    cur_tag = "R2";
    send(1, 32'hBCB51717, 0, 1, 0, 0);
    send(0, 32'h0BADF00D, 0, 1, 0, 0);
    send(1, 32'hBC954A4A, 0, 1, 0, 0);
    send(1, 32'hBCB51717, 0, 1, 0, 0);
    send(0, 32'hFFFFFFFF, 0, 1, 0, 0);
    send(1, 32'hBCB51717, 0, 1, 0, 0);
    send(1, 32'hBC957575, 0, 1, 0, 0);
    gap(1, 0, 0);

    // random mix
    cur_tag = "";
    for (int n = 0; n < 4000; n++) begin
      logic ce, sk, rw;
      int r;
      ce = ($urandom % 8) != 0;
      sk = ($urandom % 2) == 1;
      rw = ($urandom % 10) == 0;
      if (($urandom % 5) == 0) gap(ce, sk, rw);
      else begin
        r = $urandom % 20;
        w = pick_word(r < 8 ? 0 : r < 10 ? 1 : r < 12 ? 2 : r < 15 ? 3 : r < 18 ? 4 : 5, k);
        send(k, w, 8'($urandom), ce, sk, rw);
      end
    end
    gap(1, 0, 0); gap(1, 0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule